// File: doc/BRIEF.md
# Deblocking Edge Strength Generator

This block decides how hard a deblocking filter should smooth the edge between two neighbouring 4x4 blocks, called p and q. For each side it receives an intra-coded flag, a flag saying the block carries non-zero transform coefficients, a reference picture index and a motion vector given as signed x and y components in quarter-pixel units. A separate input says whether the edge lies on a macroblock boundary. The block returns one strength code from 0 to 4 for that edge, together with a valid strobe. The same code then applies to every pixel line that crosses the shared edge.

The decision is a strict priority ladder, and the first condition that is true decides the result. Intra coding gives the two strongest codes. Coefficient presence comes next. Motion or reference mismatch gives the weakest non-zero code. The result is registered. An accepted request produces its code one clock later, and the output holds its last value between requests.

Top module: `edge_strength_gen`

## Requirements
- R1: While reset is asserted and after its release, until the first request, `outValid` is 0 and `strength` is 0.
- R2: `outValid` is 1 in exactly the cycle after a cycle with `inValid` high, and 0 after a cycle with `inValid` low.
- R3: If `pIntra` or `qIntra` is set and `onMbEdge` is 1, the code is 4.
- R4: If `pIntra` or `qIntra` is set and `onMbEdge` is 0, the code is 3.
- R5: If neither side is intra and `pCoef` or `qCoef` is set, the code is 2, whatever the references and motion vectors are.
- R6: If neither side is intra or has coefficients and `pRef` differs from `qRef`, the code is 1.
- R7: Each motion vector component is a two's-complement value of MV_W bits (default 14). If no condition above holds and the absolute difference of the x components, or of the y components, is 4 or more, the code is 1. This includes the full-range case from +8191 to -8192.
- R8: In all other cases the code is 0. This includes equal references with both component differences at 3 or less.
- R9: While `inValid` is low, `strength` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; inputs are sampled in this cycle |
| onMbEdge | input | 1 | Edge lies on a macroblock boundary |
| pIntra | input | 1 | Block p is intra coded |
| qIntra | input | 1 | Block q is intra coded |
| pCoef | input | 1 | Block p has non-zero coefficients |
| qCoef | input | 1 | Block q has non-zero coefficients |
| pRef | input | REF_W | Reference picture index of p |
| qRef | input | REF_W | Reference picture index of q |
| pMvX | input | MV_W | Signed horizontal motion of p, quarter pixels |
| pMvY | input | MV_W | Signed vertical motion of p, quarter pixels |
| qMvX | input | MV_W | Signed horizontal motion of q, quarter pixels |
| qMvY | input | MV_W | Signed vertical motion of q, quarter pixels |
| outValid | output | 1 | Strength code is new this cycle |
| strength | output | 3 | Strength code, 0 to 4 |

## Verification
The block holds only two registers, so a wrong internal state is visible at the ports within one cycle. A stuck or shifted valid flag shows up as `outValid` out of step with the request. A wrong capture enable shows up as `strength` changing during idle cycles or failing to update. A wrong priority order, sign extension or threshold shows up as a wrong code on the very next cycle. The sweep covers every flag combination against motion differences on both sides of the threshold, so each of these faults reaches the code output.

// File: rtl/edge_strength_pkg.sv
package edge_strength_pkg;
  typedef enum logic [2:0] {
    STR_NONE     = 3'd0,
    STR_MOTION   = 3'd1,
    STR_COEF     = 3'd2,
    STR_INTRA    = 3'd3,
    STR_INTRA_MB = 3'd4
  } strength_t;

  typedef struct packed {
    logic capture;
  } ctrl_strobes_t;
endpackage

// File: rtl/edge_strength_ctrl.sv
module edge_strength_ctrl
  import edge_strength_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output ctrl_strobes_t strb,
  output logic          outValid
);
  always_comb strb.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: valid follows the request by exactly one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/edge_strength_dp.sv
module edge_strength_dp
  import edge_strength_pkg::*;
#(
  parameter int MV_W     = 14,
  parameter int REF_W    = 6,
  parameter int MV_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strb,
  input  logic              onMbEdge,
  input  logic              pIntra,
  input  logic              qIntra,
  input  logic              pCoef,
  input  logic              qCoef,
  input  logic [REF_W-1:0]  pRef,
  input  logic [REF_W-1:0]  qRef,
  input  logic [MV_W-1:0]   pMvX,
  input  logic [MV_W-1:0]   pMvY,
  input  logic [MV_W-1:0]   qMvX,
  input  logic [MV_W-1:0]   qMvY,
  output strength_t         strength
);
  localparam int DW = MV_W + 1;
  localparam logic [DW-1:0] LIMIT = DW'(MV_LIMIT);

  logic [MV_W-1:0] compP [2];
  logic [MV_W-1:0] compQ [2];
  logic [1:0]      compBig;

  assign compP[0] = pMvX;
  assign compP[1] = pMvY;
  assign compQ[0] = qMvX;
  assign compQ[1] = qMvY;

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic [DW-1:0] diff;
    logic [DW-1:0] mag;
    always_comb begin
      diff = {compP[c][MV_W-1], compP[c]} - {compQ[c][MV_W-1], compQ[c]};
      mag  = diff[DW-1] ? (~diff + 1'b1) : diff;
      compBig[c] = (mag >= LIMIT);
    end
  end

  logic      anyIntra, anyCoef, refDiff, mvBig;
  strength_t decided;

  always_comb begin
    anyIntra = pIntra | qIntra;
    anyCoef  = pCoef | qCoef;
    refDiff  = (pRef != qRef);
    mvBig    = |compBig;
    if (anyIntra)              decided = onMbEdge ? STR_INTRA_MB : STR_INTRA;
    else if (anyCoef)          decided = STR_COEF;
    else if (refDiff || mvBig) decided = STR_MOTION;
    else                       decided = STR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             strength <= STR_NONE;
    else if (strb.capture) strength <= decided;
  end

  // R1: code stays within range
  a_r1_range: assert property (@(posedge clk) disable iff (!rstN)
    strength <= STR_INTRA_MB);
  // R3 / R4: intra wins over everything else
  a_r3_intra_mb: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (pIntra || qIntra) && onMbEdge) |=> strength == STR_INTRA_MB);
  a_r4_intra_inner: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (pIntra || qIntra) && !onMbEdge) |=> strength == STR_INTRA);
  // R5: coefficients beat motion
  a_r5_coef: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !pIntra && !qIntra && (pCoef || qCoef)) |=> strength == STR_COEF);
  // R6: reference mismatch alone gives the weakest filtering code
  a_r6_ref: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !pIntra && !qIntra && !pCoef && !qCoef && pRef != qRef)
      |=> strength == STR_MOTION);
  // R9: idle cycles leave the code untouched
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(strength));
endmodule

// File: rtl/edge_strength_gen.sv
module edge_strength_gen
  import edge_strength_pkg::*;
#(
  parameter int MV_W     = 14,
  parameter int REF_W    = 6,
  parameter int MV_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             onMbEdge,
  input  logic             pIntra,
  input  logic             qIntra,
  input  logic             pCoef,
  input  logic             qCoef,
  input  logic [REF_W-1:0] pRef,
  input  logic [REF_W-1:0] qRef,
  input  logic [MV_W-1:0]  pMvX,
  input  logic [MV_W-1:0]  pMvY,
  input  logic [MV_W-1:0]  qMvX,
  input  logic [MV_W-1:0]  qMvY,
  output logic             outValid,
  output logic [2:0]       strength
);
  ctrl_strobes_t strb;
  strength_t     strengthEnum;

  edge_strength_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  edge_strength_dp #(.MV_W(MV_W), .REF_W(REF_W), .MV_LIMIT(MV_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .onMbEdge(onMbEdge),
    .pIntra(pIntra), .qIntra(qIntra), .pCoef(pCoef), .qCoef(qCoef),
    .pRef(pRef), .qRef(qRef), .pMvX(pMvX), .pMvY(pMvY),
    .qMvX(qMvX), .qMvY(qMvY), .strength(strengthEnum)
  );

  assign strength = strengthEnum;
endmodule

// File: tb/test_edge_strength_gen.sv
module test_edge_strength_gen;
  localparam int MV_W  = 14;
  localparam int REF_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, onMbEdge = 1'b0;
  logic pIntra = 1'b0, qIntra = 1'b0, pCoef = 1'b0, qCoef = 1'b0;
  logic [REF_W-1:0] pRef = '0, qRef = '0;
  logic [MV_W-1:0] pMvX = '0, pMvY = '0, qMvX = '0, qMvY = '0;
  logic outValid;
  logic [2:0] strength;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  edge_strength_gen #(.MV_W(MV_W), .REF_W(REF_W), .MV_LIMIT(4)) i_edge_strength_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .onMbEdge(onMbEdge),
    .pIntra(pIntra), .qIntra(qIntra), .pCoef(pCoef), .qCoef(qCoef),
    .pRef(pRef), .qRef(qRef), .pMvX(pMvX), .pMvY(pMvY),
    .qMvX(qMvX), .qMvY(qMvY), .outValid(outValid), .strength(strength)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int expCode(input int f, input int px, input int py,
                                 input int qx, input int qy);
    // f bits: 0 pIntra, 1 qIntra, 2 pCoef, 3 qCoef, 4 mbEdge, 5 refDiff
    if (f[0] || f[1]) return f[4] ? 4 : 3;
    if (f[2] || f[3]) return 2;
    if (f[5] || iabs(px - qx) >= 4 || iabs(py - qy) >= 4) return 1;
    return 0;
  endfunction

  function automatic string tagOf(input int code, input int f);
    case (code)
      4: return "R3";
      3: return "R4";
      2: return "R5";
      1: return f[5] ? "R6" : "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic request(input int f, input int px, input int py,
                         input int qx, input int qy);
    int exp;
    @(negedge clk);
    inValid = 1'b1;
    pIntra = f[0]; qIntra = f[1]; pCoef = f[2]; qCoef = f[3];
    onMbEdge = f[4];
    pRef = 6'd5; qRef = f[5] ? 6'd9 : 6'd5;
    pMvX = px[MV_W-1:0]; pMvY = py[MV_W-1:0];
    qMvX = qx[MV_W-1:0]; qMvY = qy[MV_W-1:0];
    exp = expCode(f, px, py, qx, qy);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 valid", int'(outValid), 1);
    check(tagOf(exp, f), int'(strength), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int deltas[5] = '{-4, -3, 0, 3, 4};
    int last;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", int'(outValid), 0);
    check("R1 code", int'(strength), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(outValid), 0);
    check("R1 code after release", int'(strength), 0);

    // sweep every flag combination against motion differences
    for (int f = 0; f < 64; f++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          int bx = (f % 2 == 0) ? 100 : -200;
          request(f, bx, -bx, bx + deltas[i], -bx + deltas[j]);
        end
      end
    end

    // R7: full-range extremes and sign crossing
    request(0, 8191, 0, -8192, 0);
    request(0, 0, -8192, 0, 8191);
    request(0, -2, 0, 2, 0);   // difference 4 across zero -> R7
    request(0, -2, 1, 1, -2);  // differences 3 -> R8
    request(0, 8191, 8191, 8188, 8191); // R8 at top of range
    // R5: coefficients over large motion and reference change
    request(6'b100100, 8191, 0, -8192, 0);

    // R9: idle cycles with changing inputs keep the code
    request(6'b010001, 0, 0, 0, 0);
    last = 4;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pIntra = 1'b0; qIntra = 1'b0; pCoef = k[0]; onMbEdge = 1'b0;
      pMvX = 14'(k * 1000);
      @(negedge clk);
      check("R9 hold", int'(strength), last);
      check("R2 idle", int'(outValid), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule